// File: doc/BRIEF.md
# Trigger Busy and Derandomizer Control

This block sits between a trigger source and a digitizer. It decides cycle by cycle whether an incoming trigger may start a new conversion. A trigger is taken only while the acquisition chain is idle. A taken trigger sets a conversion latch and sends a single-cycle start pulse to the converter. The converter's done strobe releases the latch.

Each finished conversion result goes into a small derandomizing queue. A processing stage drains that queue through a valid/ready handshake, so bursts of triggers are smoothed out for the consumer. When the queue is full the block holds busy, so no conversion can start that would have nowhere to land.

Three cycle counters give the dead-time figures: total cycles, busy cycles and triggers lost while busy. The dead-time fraction is the busy count divided by the total count. A synchronous clear input zeroes all three counters at once.

Top module: `trig_busy_ctrl`

## Requirements
- R1: While reset is asserted and on the first sample after it, busy_o, adc_start_o, proc_valid_o and fifo_full_o are 0 and all three counters read 0.
- R2: A trigger is accepted only in a cycle where trig_i is 1 and busy_o is 0. An accepted trigger makes adc_start_o high for exactly the next cycle; otherwise adc_start_o is 0.
- R3: busy_o is high from the cycle after an accepted trigger until the cycle after the first adc_done_i that follows it. A trigger in the same cycle as that adc_done_i is rejected.
- R4: adc_done_i while no conversion is outstanding is ignored: nothing is written to the queue and busy_o is unchanged.
- R5: adc_done_i during an outstanding conversion writes adc_data_i into the queue. Entries reach proc_data_o in write order.
- R6: fifo_full_o is 1 exactly when the queue holds DEPTH entries, and a full queue forces busy_o to 1.
- R7: proc_valid_o is 1 whenever the queue is non-empty. proc_data_o shows the oldest entry. An entry is removed in a cycle where proc_valid_o and proc_ready_i are both 1, and it stays stable while the consumer stalls.
- R8: total_cnt_o increments by one each cycle.
- R9: busy_cnt_o increments by one in each cycle where busy_o is 1.
- R10: lost_cnt_o increments by one in each cycle where trig_i is 1 while busy_o is 1.
- R11: cnt_clr_i high in a cycle makes all three counters read 0 in the next cycle, overriding that cycle's increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_i | input | 1 | Trigger request, sampled each cycle |
| adc_start_o | output | 1 | One-cycle conversion start pulse |
| adc_done_i | input | 1 | Conversion finished strobe |
| adc_data_i | input | DATA_W | Conversion result, valid with adc_done_i |
| proc_valid_o | output | 1 | Queue holds at least one result |
| proc_ready_i | input | 1 | Processing stage takes the head entry |
| proc_data_o | output | DATA_W | Oldest queued result |
| fifo_full_o | output | 1 | Queue holds DEPTH entries |
| busy_o | output | 1 | Chain cannot accept a trigger |
| cnt_clr_i | input | 1 | Synchronous clear of all counters |
| total_cnt_o | output | CNT_W | Cycles counted |
| busy_cnt_o | output | CNT_W | Busy cycles counted |
| lost_cnt_o | output | CNT_W | Triggers refused while busy |

## Verification
The bench drives several input patterns, and each one isolates a different behaviour:
- Sparse triggers with an always-ready consumer show whether the latch alone sets the dead time.
- Dense triggers with a stalled consumer fill the queue, which separates the full-forced busy from the conversion busy.
- A zero-latency converter with stray done strobes and a randomly stalling consumer exercises same-cycle start/done, ignored done pulses, and simultaneous push and pop.
- A constant trigger level puts a trigger on every done cycle, which shows that the release cycle still refuses triggers.
- Random clear pulses exercise counter clearing against concurrent increments.

// File: rtl/tbc_pkg.sv
// Package: shared types and counter indices for the trigger busy controller.
// Assumes: nothing beyond the standard language.
package tbc_pkg;

    // State of the conversion latch.
    typedef enum logic {
        CONV_IDLE   = 1'b0,
        CONV_ACTIVE = 1'b1
    } conv_state_e;

    // Indices of the statistics counters in the counter bank.
    localparam int CNT_IDX_TOTAL = 0;
    localparam int CNT_IDX_BUSY  = 1;
    localparam int CNT_IDX_LOST  = 2;
    localparam int NUM_CNT       = 3;

endpackage

// File: rtl/tbc_gate.sv
// Module: trigger gate and conversion latch.
// Accepts a trigger only when not busy, sets the conversion latch, pulses the
// converter start for one cycle and releases the latch on the done strobe.
// Assumes: the converter raises done only after a start; stray done strobes
// seen while idle are dropped here.
module tbc_gate
    import tbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic done_i,
    input  logic queue_full_i,
    output logic start_o,
    output logic busy_o,
    output logic push_o,
    output logic lost_o
);

    conv_state_e state_q;
    logic        accept;

    // Busy combines the outstanding conversion with a full queue.
    always_comb begin
        busy_o = (state_q == CONV_ACTIVE) || queue_full_i;
        accept = trig_i && !busy_o;
        push_o = (state_q == CONV_ACTIVE) && done_i;
        lost_o = trig_i && busy_o;
    end

    // Conversion latch: set on accept, cleared by done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CONV_IDLE;
        end else begin
            case (state_q)
                CONV_IDLE:   if (accept) state_q <= CONV_ACTIVE;
                CONV_ACTIVE: if (done_i) state_q <= CONV_IDLE;
                default:     state_q <= CONV_IDLE;
            endcase
        end
    end

    // Start pulse: one cycle, in the cycle after the accept.
    always_ff @(posedge clk) begin
        if (!rst_n) start_o <= 1'b0;
        else        start_o <= accept;
    end

endmodule

// File: rtl/tbc_derand_fifo.sv
// Module: derandomizing queue between converter and processing.
// Show-ahead queue: the head entry is presented with valid; a handshake pops it.
// Assumes: DEPTH >= 2; the writer never pushes into a full queue.
module tbc_derand_fifo #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr_q;
    logic [AW-1:0]     rd_ptr_q;
    logic [CW-1:0]     count_q;
    logic              pop;

    // Status and head-of-queue view.
    always_comb begin
        valid_o = (count_q != '0);
        full_o  = (count_q == FULL_CNT);
        data_o  = mem[rd_ptr_q];
        pop     = valid_o && ready_i;
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push_i) mem[wr_ptr_q] <= push_data_i;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_i) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
            if (pop)    rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
            case ({push_i, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

endmodule

// File: rtl/tbc_counter.sv
// Module: one statistics counter with synchronous clear.
// Assumes: wrap-around at 2**W is acceptable for the chosen width.
module tbc_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] q_o
);

    // Clear takes priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) q_o <= '0;
        else if (inc_i)      q_o <= q_o + 1'b1;
    end

endmodule

// File: rtl/trig_busy_ctrl.sv
// Module: trigger busy and derandomizer control, top level.
// Gates triggers against the busy state, drives the converter start and
// collects results in a derandomizing queue. Three counters give total
// cycles, busy cycles and lost triggers for the dead-time figure.
// Assumes: a converter with a start/done handshake; one conversion at a time.
module trig_busy_ctrl
    import tbc_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    output logic              adc_start_o,
    input  logic              adc_done_i,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic              proc_valid_o,
    input  logic              proc_ready_i,
    output logic [DATA_W-1:0] proc_data_o,
    output logic              fifo_full_o,
    output logic              busy_o,
    input  logic              cnt_clr_i,
    output logic [CNT_W-1:0]  total_cnt_o,
    output logic [CNT_W-1:0]  busy_cnt_o,
    output logic [CNT_W-1:0]  lost_cnt_o
);

    logic               push;
    logic               lost;
    logic [NUM_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0]   cnt_val [NUM_CNT];

    tbc_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_i       (trig_i),
        .done_i       (adc_done_i),
        .queue_full_i (fifo_full_o),
        .start_o      (adc_start_o),
        .busy_o       (busy_o),
        .push_o       (push),
        .lost_o       (lost)
    );

    tbc_derand_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_data_i (adc_data_i),
        .ready_i     (proc_ready_i),
        .valid_o     (proc_valid_o),
        .data_o      (proc_data_o),
        .full_o      (fifo_full_o)
    );

    // Increment enables for the counter bank.
    always_comb begin
        cnt_inc                = '0;
        cnt_inc[CNT_IDX_TOTAL] = 1'b1;
        cnt_inc[CNT_IDX_BUSY]  = busy_o;
        cnt_inc[CNT_IDX_LOST]  = lost;
    end

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        tbc_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (cnt_clr_i),
            .inc_i (cnt_inc[gi]),
            .q_o   (cnt_val[gi])
        );
    end

    assign total_cnt_o = cnt_val[CNT_IDX_TOTAL];
    assign busy_cnt_o  = cnt_val[CNT_IDX_BUSY];
    assign lost_cnt_o  = cnt_val[CNT_IDX_LOST];

endmodule

// File: rtl/tbc_checker.sv
// Module: property checker for trig_busy_ctrl, attached by bind.
// Assumes: observes the top-level ports only.
module tbc_checker #(
    parameter int DATA_W = 12,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig_i,
    input logic              adc_start_o,
    input logic              adc_done_i,
    input logic              proc_valid_o,
    input logic              proc_ready_i,
    input logic [DATA_W-1:0] proc_data_o,
    input logic              fifo_full_o,
    input logic              busy_o,
    input logic              cnt_clr_i,
    input logic [CNT_W-1:0]  total_cnt_o,
    input logic [CNT_W-1:0]  busy_cnt_o,
    input logic [CNT_W-1:0]  lost_cnt_o
);

    // R2: start is a single-cycle pulse
    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o |=> !adc_start_o);

    // R2: start only follows a trigger taken while not busy
    p_start_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_start_o) |-> $past(trig_i && !busy_o));

    // R3: busy holds while the start pulse is out
    p_busy_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o |-> busy_o);

    // R3: busy falls only after a done strobe or a queue pop
    p_busy_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(adc_done_i || (proc_valid_o && proc_ready_i)));

    // R6: a full queue forces busy
    p_full_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full_o |-> busy_o);

    // R7: head entry holds while the consumer stalls
    p_head_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_valid_o && !proc_ready_i) |=> (proc_valid_o && $stable(proc_data_o)));

    // R8: total counter advances each cycle
    p_total_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr_i |=> (total_cnt_o == $past(total_cnt_o) + 1'b1));

    // R9: busy counter advances on busy cycles
    p_busy_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !cnt_clr_i) |=> (busy_cnt_o == $past(busy_cnt_o) + 1'b1));

    // R10: lost counter advances on refused triggers
    p_lost_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && busy_o && !cnt_clr_i) |=> (lost_cnt_o == $past(lost_cnt_o) + 1'b1));

    // R11: clear zeroes all counters
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr_i |=> (total_cnt_o == '0 && busy_cnt_o == '0 && lost_cnt_o == '0));

endmodule

bind trig_busy_ctrl tbc_checker #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_tbc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_i       (trig_i),
    .adc_start_o  (adc_start_o),
    .adc_done_i   (adc_done_i),
    .proc_valid_o (proc_valid_o),
    .proc_ready_i (proc_ready_i),
    .proc_data_o  (proc_data_o),
    .fifo_full_o  (fifo_full_o),
    .busy_o       (busy_o),
    .cnt_clr_i    (cnt_clr_i),
    .total_cnt_o  (total_cnt_o),
    .busy_cnt_o   (busy_cnt_o),
    .lost_cnt_o   (lost_cnt_o)
);

// File: tb/tb_trig_busy_ctrl.sv
// Bench: behavioural reference model compared against the design every cycle.
module tb_trig_busy_ctrl;

    localparam int DATA_W = 12;
    localparam int DEPTH  = 8;
    localparam int CNT_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              trig_i;
    logic              adc_start_o;
    logic              adc_done_i;
    logic [DATA_W-1:0] adc_data_i;
    logic              proc_valid_o;
    logic              proc_ready_i;
    logic [DATA_W-1:0] proc_data_o;
    logic              fifo_full_o;
    logic              busy_o;
    logic              cnt_clr_i;
    logic [CNT_W-1:0]  total_cnt_o;
    logic [CNT_W-1:0]  busy_cnt_o;
    logic [CNT_W-1:0]  lost_cnt_o;

    trig_busy_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .adc_start_o(adc_start_o),
        .adc_done_i(adc_done_i), .adc_data_i(adc_data_i),
        .proc_valid_o(proc_valid_o), .proc_ready_i(proc_ready_i),
        .proc_data_o(proc_data_o), .fifo_full_o(fifo_full_o), .busy_o(busy_o),
        .cnt_clr_i(cnt_clr_i), .total_cnt_o(total_cnt_o),
        .busy_cnt_o(busy_cnt_o), .lost_cnt_o(lost_cnt_o)
    );

    always #10 clk = ~clk;

    // Reference model state
    bit                m_conv;
    bit                m_start;
    logic [DATA_W-1:0] m_q[$];
    longint            m_total, m_busy, m_lost;

    int  n_cmp  = 0;
    int  n_fail = 0;
    int  adc_cd = -1;
    int  lat    = 3;
    bit  coin_pending = 0;
    bit  finished = 0;

    // Model update on each rising edge from the inputs held since the falling edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_conv = 0; m_start = 0; m_q.delete();
            m_total = 0; m_busy = 0; m_lost = 0;
        end else begin
            bit b, acc, push, pop;
            b    = m_conv || (m_q.size() == DEPTH);
            acc  = trig_i && !b;
            push = m_conv && adc_done_i;
            pop  = (m_q.size() > 0) && proc_ready_i;
            if (cnt_clr_i) begin
                m_total = 0; m_busy = 0; m_lost = 0;
            end else begin
                m_total++;
                if (b) m_busy++;
                if (trig_i && b) m_lost++;
            end
            if (pop)  void'(m_q.pop_front());
            if (push) m_q.push_back(adc_data_i);
            if (m_conv) m_conv = !adc_done_i;
            else        m_conv = acc;
            m_start = acc;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        bit full;
        full = (m_q.size() == DEPTH);
        chk("R2 start", adc_start_o, m_start);
        chk("R3 busy", busy_o, m_conv || full);
        chk("R6 full", fifo_full_o, full);
        chk("R7 valid (R4 stray done)", proc_valid_o, m_q.size() > 0);
        if (m_q.size() > 0) chk("R5 data order", proc_data_o, m_q[0]);
        chk("R8 total", total_cnt_o, m_total & 32'hFFFF_FFFF);
        chk("R9 busy count", busy_cnt_o, m_busy & 32'hFFFF_FFFF);
        chk("R10 lost count", lost_cnt_o, m_lost & 32'hFFFF_FFFF);
    endtask

    // One phase of stimulus: percentages for trigger, ready, stray done and clear
    task automatic run_phase(input int cycles, input int trig_pct, input int rdy_pct,
                             input int latency, input int spur_pct, input int clr_pct,
                             input bit trig_level);
        lat = latency;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (coin_pending) begin
                chk("R3 coincident trigger rejected", adc_start_o, 0);
                coin_pending = 0;
            end
            compare_all();
            trig_i       = trig_level ? 1'b1 : ($urandom_range(99) < trig_pct);
            proc_ready_i = ($urandom_range(99) < rdy_pct);
            cnt_clr_i    = ($urandom_range(999) < clr_pct);
            adc_data_i   = DATA_W'($urandom);
            adc_done_i   = 1'b0;
            if (m_start) adc_cd = lat;
            if (adc_cd == 0) begin
                adc_done_i = 1'b1;
                adc_cd = -1;
            end else if (adc_cd > 0) begin
                adc_cd--;
            end else if (!m_conv && $urandom_range(99) < spur_pct) begin
                adc_done_i = 1'b1;
            end
            if (trig_i && adc_done_i && m_conv) coin_pending = 1;
        end
    endtask

    initial begin
        rst_n = 1'b0; trig_i = 0; adc_done_i = 0; adc_data_i = '0;
        proc_ready_i = 0; cnt_clr_i = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", busy_o, 0);
        chk("R1 start", adc_start_o, 0);
        chk("R1 valid", proc_valid_o, 0);
        chk("R1 full", fifo_full_o, 0);
        chk("R1 counters", total_cnt_o | busy_cnt_o | lost_cnt_o, 0);
        rst_n = 1'b1;
        run_phase(800,  10, 100, 3, 0,  0, 0);   // sparse, consumer always ready
        run_phase(600,  80,   0, 2, 0,  0, 0);   // stalled consumer fills queue (R6)
        run_phase(1500, 50,  40, 0, 30, 0, 0);   // zero latency, stray done (R4)
        run_phase(600,   0, 100, 1, 0, 20, 1);   // constant trigger, coincidence (R3), clears (R11)
        run_phase(1500, 60,  60, 4, 10, 5, 0);   // mixed
        @(negedge clk);
        compare_all();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_cmp++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

endmodule